// File: doc/BRIEF.md
# Flash Write-Command Sequencer with Boot Lockout

This block models the write side of a word-wide flash memory. The host issues bus write cycles with an active-low write strobe. The address is captured when the strobe falls and the data when it rises. A decoder follows multi-cycle command sequences and starts a word program, a sector erase or a chip erase. It can also set a one-way lockout on the boot region, or switch reads into an identification view. The array is a small register memory. A parameterized cycle counter stands in for the embedded program and erase timers, and `busy_o` is high while one of these operations runs.

Every command opens with two unlock cycles: AAh to 5555h, then 55h to 2AAAh. Once the boot lockout is set, program and both erase kinds leave the boot words untouched and still modify every other word. A high-voltage override input lifts this protection while it is held. The lockout state can be read back in identification mode.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset every array word reads FFFFh, `busy_o` is low, the lockout is clear and reads return array data.
- R2: The program sequence is AAh@5555h, 55h@2AAAh, A0h@5555h, then data@target. When the operation ends, the target word becomes its old value ANDed with the data, so programming can only clear bits.
- R3: The address of a write cycle is the value of `addr_i` on the clock where `we_ni` is first seen low. The data is the value of `wdata_i` on the clock where `we_ni` is first seen high again.
- R4: A cycle that does not match the next step of any sequence returns the decoder to idle, and that cycle takes no effect.
- R5: The sector erase sequence is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 30h@sector. The sectors are: words 8–15 (parameter 0), words 16–23 (parameter 1), and words 0–7 together with 24–63 (boot plus main). The addressed sector is set to FFFFh.
- R6: Chip erase uses the same first five cycles as sector erase followed by 10h@5555h. It sets every word to FFFFh, and reads return data afterwards.
- R7: `busy_o` is high for exactly 12 (program), 32 (sector erase) or 40 (chip erase) cycles, starting right after the final rising strobe. Write cycles that complete while it is high are ignored.
- R8: The lockout sequence uses the same first five cycles followed by 40h@5555h. Afterwards, program, sector erase and chip erase leave words 0–7 unchanged and still modify all other words.
- R9: While `hv_override_i` is high, the boot words can be programmed and erased despite the lockout. The override is sampled when the operation completes, so protection applies again as soon as it drops.
- R10: The lockout is sticky. No command clears it. Only `rst_ni` does.
- R11: AAh@5555h, 55h@2AAAh, 90h@5555h enters identification mode. In that mode address 0 reads 00C3h, address 1 reads 5A96h, address 2 reads the lockout in bit 0 (1 = locked), and all other addresses read 0. AAh@5555h, 55h@2AAAh, F0h@5555h returns to array reads.
- R12: Reads are combinational from `addr_i` (array bits 5:0). While an operation is busy, reads show the contents from before the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_ni | input | 1 | Write strobe, active low |
| addr_i | input | 16 | Word address for write cycles and reads |
| wdata_i | input | 16 | Write data |
| hv_override_i | input | 1 | Boot protection override |
| rdata_o | output | 16 | Read data |
| busy_o | output | 1 | Embedded operation in progress |

## Verification
On every cycle, the assertions check that the decoder holds its state while busy and that read data holds steady during an operation. They also check that busy rises only after a completed write cycle, that busy never outlasts the longest operation, and that the lockout never clears. Only the bench scenarios can show the array effects. These are the AND-only program result, the sector boundaries, the exclusion of the boot words under lockout and its lifting by the override, the sampling edges for address and data, and the identification readback.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PDATA, ST_ERS3, ST_ERS4, ST_ERS5
  } dec_state_e;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_CHIP} op_e;

  localparam logic [15:0] UNLOCK_A1 = 16'h5555;
  localparam logic [15:0] UNLOCK_A2 = 16'h2AAA;
  localparam logic [7:0] CD_UNL1 = 8'hAA;
  localparam logic [7:0] CD_UNL2 = 8'h55;
  localparam logic [7:0] CD_PROG = 8'hA0;
  localparam logic [7:0] CD_ERSP = 8'h80;
  localparam logic [7:0] CD_IDIN = 8'h90;
  localparam logic [7:0] CD_IDEX = 8'hF0;
  localparam logic [7:0] CD_SECT = 8'h30;
  localparam logic [7:0] CD_CHIP = 8'h10;
  localparam logic [7:0] CD_LOCK = 8'h40;
endpackage

// File: rtl/flash_bus_edge.sv
module flash_bus_edge #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  output logic          cyc_o,
  output logic [AW-1:0] cyc_addr_o
);
  logic          we_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      we_q <= we_ni;
      if (we_q && !we_ni) addr_q <= addr_i;
    end
  end

  // cycle completes on the rising strobe
  assign cyc_o      = !we_q && we_ni;
  assign cyc_addr_o = addr_q;
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int ARR_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_i,
  input  logic [AW-1:0]     cyc_addr_i,
  input  logic [DW-1:0]     cyc_data_i,
  input  logic              busy_i,
  output logic              start_o,
  output op_e               start_op_o,
  output logic [ARR_AW-1:0] start_addr_o,
  output logic [DW-1:0]     start_data_o,
  output logic              lock_set_o,
  output logic              id_enter_o,
  output logic              id_exit_o,
  output dec_state_e        state_o
);
  dec_state_e state_q, state_d;
  logic accept, at_a1, at_a2;
  logic [7:0] code;

  assign accept = cyc_i && !busy_i;
  assign at_a1  = cyc_addr_i == AW'(UNLOCK_A1);
  assign at_a2  = cyc_addr_i == AW'(UNLOCK_A2);
  assign code   = cyc_data_i[7:0];

  always_comb begin
    state_d    = state_q;
    start_o    = 1'b0;
    start_op_o = OP_NONE;
    lock_set_o = 1'b0;
    id_enter_o = 1'b0;
    id_exit_o  = 1'b0;
    if (accept) begin
      state_d = ST_IDLE;
      unique case (state_q)
        ST_IDLE: if (code == CD_UNL1 && at_a1) state_d = ST_UNL1;
        ST_UNL1: if (code == CD_UNL2 && at_a2) state_d = ST_UNL2;
        ST_UNL2: if (at_a1) begin
          if (code == CD_PROG)      state_d = ST_PDATA;
          else if (code == CD_ERSP) state_d = ST_ERS3;
          else if (code == CD_IDIN) id_enter_o = 1'b1;
          else if (code == CD_IDEX) id_exit_o = 1'b1;
        end
        ST_PDATA: begin
          start_o    = 1'b1;
          start_op_o = OP_PROG;
        end
        ST_ERS3: if (code == CD_UNL1 && at_a1) state_d = ST_ERS4;
        ST_ERS4: if (code == CD_UNL2 && at_a2) state_d = ST_ERS5;
        ST_ERS5: begin
          if (code == CD_SECT) begin
            start_o    = 1'b1;
            start_op_o = OP_SECT;
          end else if (code == CD_CHIP && at_a1) begin
            start_o    = 1'b1;
            start_op_o = OP_CHIP;
          end else if (code == CD_LOCK && at_a1) begin
            lock_set_o = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign start_addr_o = cyc_addr_i[ARR_AW-1:0];
  assign start_data_o = cyc_data_i;
  assign state_o      = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_cmd_pkg::*;
#(
  parameter int ARR_AW   = 6,
  parameter int DW       = 16,
  parameter int PROG_CYC = 12,
  parameter int SECT_CYC = 32,
  parameter int CHIP_CYC = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic [ARR_AW-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  output logic              busy_o,
  output logic              done_o,
  output op_e               op_o,
  output logic [ARR_AW-1:0] addr_o,
  output logic [DW-1:0]     data_o
);
  localparam int MAX_A  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_C  = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
  localparam int CW     = $clog2(MAX_C + 1);

  logic [CW-1:0]     cnt_q;
  logic              busy_q;
  op_e               op_q;
  logic [ARR_AW-1:0] addr_q;
  logic [DW-1:0]     data_q;

  function automatic logic [CW-1:0] dur(op_e op);
    unique case (op)
      OP_PROG: dur = CW'(PROG_CYC);
      OP_SECT: dur = CW'(SECT_CYC);
      OP_CHIP: dur = CW'(CHIP_CYC);
      default: dur = CW'(1);
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= dur(op_i);
      op_q   <= op_i;
      addr_q <= addr_i;
      data_q <= data_i;
    end else if (busy_q) begin
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
      else                 cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CW'(1));
  assign op_o   = op_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_cmd_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int ARR_AW  = 6,
  parameter int BOOT_W  = 8,
  parameter int PARAM_W = 8,
  parameter logic [DW-1:0] ID_MFR = 16'h00C3,
  parameter logic [DW-1:0] ID_DEV = 16'h5A96
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  op_e               op_i,
  input  logic [ARR_AW-1:0] op_addr_i,
  input  logic [DW-1:0]     op_data_i,
  input  logic              lock_i,
  input  logic              hv_i,
  input  logic              id_mode_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DW-1:0]     rdata_o
);
  localparam int NW = 1 << ARR_AW;
  localparam int P0_LO = BOOT_W;
  localparam int P1_LO = BOOT_W + PARAM_W;
  localparam int P1_HI = BOOT_W + 2 * PARAM_W;

  function automatic logic [1:0] sector_of(int unsigned idx);
    if (idx >= P0_LO && idx < P1_LO)      sector_of = 2'd0;
    else if (idx >= P1_LO && idx < P1_HI) sector_of = 2'd1;
    else                                  sector_of = 2'd2;
  endfunction

  logic [DW-1:0] words [NW];
  logic [1:0]    op_sect;

  assign op_sect = sector_of(32'(op_addr_i));

  for (genvar i = 0; i < NW; i++) begin : g_word
    localparam bit         IN_BOOT = (i < BOOT_W);
    localparam logic [1:0] SECT    = sector_of(i);
    logic [DW-1:0] word_q;
    logic          guard;

    assign guard = IN_BOOT && lock_i && !hv_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '1;
      end else if (done_i && !guard) begin
        unique case (op_i)
          OP_PROG: if (op_addr_i == ARR_AW'(i)) word_q <= word_q & op_data_i;
          OP_SECT: if (op_sect == SECT) word_q <= '1;
          OP_CHIP: word_q <= '1;
          default: ;
        endcase
      end
    end

    assign words[i] = word_q;
  end

  always_comb begin
    rdata_o = words[rd_addr_i[ARR_AW-1:0]];
    if (id_mode_i) begin
      if (rd_addr_i == AW'(0))      rdata_o = ID_MFR;
      else if (rd_addr_i == AW'(1)) rdata_o = ID_DEV;
      else if (rd_addr_i == AW'(2)) rdata_o = DW'(lock_i);
      else                          rdata_o = '0;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int ARR_AW   = 6,
  parameter int BOOT_W   = 8,
  parameter int PARAM_W  = 8,
  parameter int PROG_CYC = 12,
  parameter int SECT_CYC = 32,
  parameter int CHIP_CYC = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          hv_override_i,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o
);
  localparam int MAX_A   = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_CYC = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;

  logic              cyc;
  logic [AW-1:0]     cyc_addr;
  logic              tmr_start, lock_set, id_enter, id_exit;
  op_e               start_op, run_op;
  logic [ARR_AW-1:0] start_addr, run_addr;
  logic [DW-1:0]     start_data, run_data;
  logic              done;
  dec_state_e        dec_state;
  logic              lock_q, id_mode_q;

  flash_bus_edge #(.AW(AW)) u_edge (
    .clk_i, .rst_ni, .we_ni, .addr_i,
    .cyc_o(cyc), .cyc_addr_o(cyc_addr)
  );

  flash_cmd_decode #(.AW(AW), .DW(DW), .ARR_AW(ARR_AW)) u_dec (
    .clk_i, .rst_ni,
    .cyc_i(cyc), .cyc_addr_i(cyc_addr), .cyc_data_i(wdata_i), .busy_i(busy_o),
    .start_o(tmr_start), .start_op_o(start_op), .start_addr_o(start_addr),
    .start_data_o(start_data), .lock_set_o(lock_set),
    .id_enter_o(id_enter), .id_exit_o(id_exit), .state_o(dec_state)
  );

  flash_op_timer #(
    .ARR_AW(ARR_AW), .DW(DW),
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_tmr (
    .clk_i, .rst_ni,
    .start_i(tmr_start), .op_i(start_op), .addr_i(start_addr), .data_i(start_data),
    .busy_o(busy_o), .done_o(done), .op_o(run_op), .addr_o(run_addr), .data_o(run_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q    <= 1'b0;
      id_mode_q <= 1'b0;
    end else begin
      if (lock_set) lock_q <= 1'b1;
      if (id_enter)     id_mode_q <= 1'b1;
      else if (id_exit) id_mode_q <= 1'b0;
    end
  end

  flash_array #(
    .AW(AW), .DW(DW), .ARR_AW(ARR_AW), .BOOT_W(BOOT_W), .PARAM_W(PARAM_W)
  ) u_arr (
    .clk_i, .rst_ni,
    .done_i(done), .op_i(run_op), .op_addr_i(run_addr), .op_data_i(run_data),
    .lock_i(lock_q), .hv_i(hv_override_i), .id_mode_i(id_mode_q),
    .rd_addr_i(addr_i), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int MAX_CYC = 40
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] rdata_o,
  input logic          cyc,
  input logic          lock_q,
  input logic [2:0]    dec_state
);
  localparam int CW = $clog2(MAX_CYC + 2);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + CW'(1);
    else             run_cnt <= '0;
  end

  assert_busy_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_cnt < CW'(MAX_CYC)));

  assert_ignore_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (dec_state == $past(dec_state)));

  assert_busy_from_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cyc));

  assert_lock_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_q) |-> lock_q);

  assert_read_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && addr_i == $past(addr_i)) |-> (rdata_o == $past(rdata_o)));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW), .DW(DW), .MAX_CYC(MAX_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .addr_i(addr_i),
  .rdata_o(rdata_o), .cyc(cyc), .lock_q(lock_q), .dec_state(dec_state)
);

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/100ps
module flash_cmd_seq_tb;
  localparam int NW = 64, BOOT_W = 8, PARAM_W = 8;
  localparam int PROG_CYC = 12, SECT_CYC = 32, CHIP_CYC = 40;

  logic        clk = 1'b0, rst_ni = 1'b0, we_ni = 1'b1, hv = 1'b0;
  logic [15:0] addr = '0, wdata = '0, rdata;
  logic        busy;
  logic [15:0] mdl [NW];
  bit          mdl_lock;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_ni(we_ni), .addr_i(addr), .wdata_i(wdata),
    .hv_override_i(hv), .rdata_o(rdata), .busy_o(busy)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int sector_of(int i);
    if (i >= BOOT_W && i < BOOT_W + PARAM_W) return 0;
    if (i >= BOOT_W + PARAM_W && i < BOOT_W + 2 * PARAM_W) return 1;
    return 2;
  endfunction

  function automatic bit guarded(int i, bit hv_at_end);
    return i < BOOT_W && mdl_lock && !hv_at_end;
  endfunction

  task automatic mdl_reset();
    for (int i = 0; i < NW; i++) mdl[i] = 16'hFFFF;
    mdl_lock = 0;
  endtask

  task automatic mdl_prog(int a, logic [15:0] d, bit h);
    if (!guarded(a, h)) mdl[a] = mdl[a] & d;
  endtask

  task automatic mdl_erase(int s, bit all, bit h);
    for (int i = 0; i < NW; i++)
      if (!guarded(i, h) && (all || sector_of(i) == s)) mdl[i] = 16'hFFFF;
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk); we_ni = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    @(negedge clk); we_ni = 1'b1;
    @(negedge clk);
  endtask

  // address moved and data changed while strobe is low (R3)
  task automatic wr_skew(logic [15:0] a, logic [15:0] d);
    @(negedge clk); we_ni = 1'b0; addr = a; wdata = ~d;
    @(negedge clk); addr = a + 16'd1; wdata = d;
    @(negedge clk); we_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic unl();
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055);
  endtask
  task automatic cmd_prog(logic [15:0] a, logic [15:0] d);
    unl(); wr(16'h5555, 16'h00A0); wr(a, d);
  endtask
  task automatic ers_pre();
    unl(); wr(16'h5555, 16'h0080); unl();
  endtask
  task automatic cmd_sect(logic [15:0] a);
    ers_pre(); wr(a, 16'h0030);
  endtask
  task automatic cmd_chip();
    ers_pre(); wr(16'h5555, 16'h0010);
  endtask
  task automatic cmd_lock();
    ers_pre(); wr(16'h5555, 16'h0040);
  endtask
  task automatic id_in();
    unl(); wr(16'h5555, 16'h0090);
  endtask
  task automatic id_out();
    unl(); wr(16'h5555, 16'h00F0);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic cmp_all(string req);
    logic [15:0] d;
    int bad = -1;
    logic [15:0] bad_d = '0;
    for (int i = 0; i < NW; i++) begin
      rd(16'(i), d);
      if (d !== mdl[i] && bad < 0) begin bad = i; bad_d = d; end
    end
    if (bad < 0) chk(req, 16'h0, 16'h0);
    else begin
      $display("  mismatch at word %0d", bad);
      chk(req, bad_d, mdl[bad]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; we_ni = 1'b1; hv = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    mdl_reset();
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n;
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 busy", 16'(busy), 16'h0);
    cmp_all("R1 erased");

    // R2 program and busy length R7
    cmd_prog(16'd30, 16'h1234); wait_idle(n); mdl_prog(30, 16'h1234, 0);
    chk("R7 prog busy", 16'(n), 16'(PROG_CYC));
    rd(16'd30, d); chk("R2 program", d, 16'h1234);
    cmd_prog(16'd30, 16'hFF0F); wait_idle(n); mdl_prog(30, 16'hFF0F, 0);
    rd(16'd30, d); chk("R2 and-only", d, 16'h1204);

    // R12 read during busy shows old contents
    cmd_prog(16'd31, 16'h0000);
    rd(16'd31, d); chk("R12 busy read", d, 16'hFFFF);
    wait_idle(n); mdl_prog(31, 16'h0000, 0);
    rd(16'd31, d); chk("R12 after", d, 16'h0000);

    // R3 address at falling, data at rising
    unl(); wr(16'h5555, 16'h00A0); wr_skew(16'd40, 16'h00F0);
    wait_idle(n); mdl_prog(40, 16'h00F0, 0);
    rd(16'd40, d); chk("R3 addr/data", d, 16'h00F0);
    rd(16'd41, d); chk("R3 other word", d, 16'hFFFF);

    // R4 mismatched cycles
    unl(); wr(16'h5555, 16'h0077); wr(16'd42, 16'h0000);
    wr(16'h5555, 16'h00AA); wr(16'h2AAB, 16'h0055); wr(16'h5555, 16'h00A0); wr(16'd43, 16'h0000);
    chk("R4 no busy", 16'(busy), 16'h0);
    cmp_all("R4 unchanged");

    // R5 sector erase
    cmd_prog(16'd9, 0);  wait_idle(n); mdl_prog(9, 0, 0);
    cmd_prog(16'd17, 0); wait_idle(n); mdl_prog(17, 0, 0);
    cmd_prog(16'd3, 0);  wait_idle(n); mdl_prog(3, 0, 0);
    cmd_prog(16'd50, 0); wait_idle(n); mdl_prog(50, 0, 0);
    cmd_sect(16'd10); wait_idle(n); mdl_erase(0, 0, 0);
    chk("R7 sect busy", 16'(n), 16'(SECT_CYC));
    rd(16'd9, d);  chk("R5 param0 erased", d, 16'hFFFF);
    rd(16'd17, d); chk("R5 param1 kept", d, 16'h0000);
    cmd_sect(16'd60); wait_idle(n); mdl_erase(2, 0, 0);
    rd(16'd3, d); chk("R5 boot+main erased", d, 16'hFFFF);
    cmp_all("R5 sectors");

    // R6 chip erase
    cmd_chip(); wait_idle(n); mdl_erase(0, 1, 0);
    chk("R7 chip busy", 16'(n), 16'(CHIP_CYC));
    cmp_all("R6 chip erase");

    // R7 writes ignored while busy
    cmd_prog(16'd20, 16'h0F0F); wait_idle(n); mdl_prog(20, 16'h0F0F, 0);
    cmd_chip();
    cmd_prog(16'd21, 16'h0000);
    wait_idle(n); mdl_erase(0, 1, 0);
    cmp_all("R7 ignored during busy");
    cmd_prog(16'd22, 16'h1111); wait_idle(n); mdl_prog(22, 16'h1111, 0);
    rd(16'd22, d); chk("R7 decoder usable", d, 16'h1111);

    // R11 identification
    id_in();
    rd(16'd0, d); chk("R11 mfr", d, 16'h00C3);
    rd(16'd1, d); chk("R11 dev", d, 16'h5A96);
    rd(16'd2, d); chk("R11 lock clear", d, 16'h0000);
    rd(16'd22, d); chk("R11 other", d, 16'h0000);
    id_out();
    rd(16'd22, d); chk("R11 exit", d, 16'h1111);

    // R8 lockout
    cmd_prog(16'd5, 16'h0F0F); wait_idle(n); mdl_prog(5, 16'h0F0F, 0);
    cmd_lock(); mdl_lock = 1;
    id_in(); rd(16'd2, d); chk("R11 lock set", d, 16'h0001); id_out();
    cmd_prog(16'd2, 0); wait_idle(n); mdl_prog(2, 0, 0);
    rd(16'd2, d); chk("R8 boot program", d, 16'hFFFF);
    cmd_prog(16'd30, 0); wait_idle(n); mdl_prog(30, 0, 0);
    cmd_prog(16'd12, 0); wait_idle(n); mdl_prog(12, 0, 0);
    cmd_sect(16'd0); wait_idle(n); mdl_erase(2, 0, 0);
    rd(16'd5, d); chk("R8 boot sector erase", d, 16'h0F0F);
    rd(16'd30, d); chk("R8 main erased", d, 16'hFFFF);
    cmd_chip(); wait_idle(n); mdl_erase(0, 1, 0);
    rd(16'd5, d); chk("R8 boot chip erase", d, 16'h0F0F);
    cmp_all("R8 lockout");

    // R9 override
    hv = 1'b1;
    cmd_prog(16'd5, 16'h00FF); wait_idle(n); mdl_prog(5, 16'h00FF, 1);
    rd(16'd5, d); chk("R9 override program", d, 16'h000F);
    cmd_sect(16'd3); wait_idle(n); mdl_erase(2, 0, 1);
    rd(16'd5, d); chk("R9 override erase", d, 16'hFFFF);
    hv = 1'b0;
    cmd_prog(16'd6, 0); wait_idle(n); mdl_prog(6, 0, 0);
    rd(16'd6, d); chk("R9 override released", d, 16'hFFFF);
    hv = 1'b1;
    cmd_prog(16'd7, 0);
    @(negedge clk); hv = 1'b0;
    wait_idle(n); mdl_prog(7, 0, 0);
    rd(16'd7, d); chk("R9 sampled at end", d, 16'hFFFF);

    // R10 sticky
    id_out(); cmd_chip(); wait_idle(n); mdl_erase(0, 1, 0);
    id_in(); rd(16'd2, d); chk("R10 still locked", d, 16'h0001); id_out();
    do_reset();
    id_in(); rd(16'd2, d); chk("R10 cleared by reset", d, 16'h0000); id_out();
    cmp_all("R1 after reset");

    // random mix
    void'($urandom(32'd20240611));
    for (int it = 0; it < 120; it++) begin
      int r = int'($urandom % 8);
      if (it == 60) begin cmd_lock(); mdl_lock = 1; end
      if (r == 0) begin
        int a = int'($urandom % NW);
        cmd_sect(16'(a)); wait_idle(n); mdl_erase(sector_of(a), 0, hv);
      end else if (r == 1) begin
        hv = 1'($urandom % 2);
      end else begin
        int a = int'($urandom % NW);
        logic [15:0] v = 16'($urandom);
        cmd_prog(16'(a), v); wait_idle(n); mdl_prog(a, v, hv);
      end
      if (it % 10 == 9) cmp_all("R2 R5 R8 R9 random");
    end
    cmp_all("R8 random final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule